// File: doc/BRIEF.md
# I2C Target Controller with Status Tracking

This block is the target side of an I2C bus. It oversamples SCL and SDA with the system clock and finds start, repeated-start and stop conditions. It shifts in the first byte after each start and checks the 7-bit address against four programmable identities. It also recognizes the start byte 0x01 and the general-call address 0x00. The block acknowledges by pulling SDA low in the ninth clock. For a read it serves bytes from a 2-entry transmit FIFO. For a write it stores bytes in a 2-entry receive FIFO.

A 16-bit status word records what happened on the bus. Each field has its own set and clear rule: stop clears some bits, a status read clears one, a control-bit write clears others. The interrupt output is raised when a stop ends a transfer that had been matched. Software reaches everything through a small register port with a 3-bit select: 0 status, 1 control, 2..5 identities 0..3, 6 alternative identity, 7 data. Writing select 7 pushes the transmit FIFO, and reading select 7 pops the receive FIFO.

Top module: `i2c_tgt_status`

## Requirements
- R1: After reset the status word reads 0x0000, SDA is not driven and the interrupt is low.
- R2: A first byte whose upper 7 bits equal identity k is acknowledged. Bits 12:11 then hold k (lowest k wins on equal identities), and bits 14 (matched) and 6 (busy) read 1. The target changes SDA only while SCL is low.
- R3: A first byte that matches nothing is not acknowledged, clears bit 6 and leaves bit 14 at 0. A stop after it does not set bit 10.
- R4: A stop clears bits 14, 13 and 6. If bit 14 was set, the stop sets bit 10. The interrupt output equals bit 10 AND control bit 2. A status read returns the old value and clears bit 10.
- R5: A start seen while a transfer is in progress sets bit 13 (repeated start).
- R6: A matched read address (first-byte bit 0 = 1) is acknowledged only if the transmit FIFO holds data and control bit 1 (force NACK) is 0. Otherwise it is NACKed and bit 5 reads 1, and bit 5 reads 0 after any acknowledged address or data byte. Transmit bytes go out MSB first, a new byte after each master ACK.
- R7: Bytes written to a matched address are acknowledged and queued in the receive FIFO. Reads of select 7 return them in order, and return 0x0000 once the FIFO is empty.
- R8: A first byte of 0x01 (start byte) sets bit 14 and is not acknowledged.
- R9: Address 0x00 is acknowledged only when control bit 0 is 1. The byte after it sets bit 7 and writes bits 9:8: 0x06 gives 01, 0x04 gives 10, and an odd byte whose upper 7 bits equal the alternative identity gives 11. Odd bytes are queued in the receive FIFO and even command bytes are not.
- R10: General-call command 0x06 returns the identities, alternative identity and control register to 0 and empties both FIFOs. Bits 9:7 keep the values it just set.
- R11: Writing control with bit 3 = 1 clears bits 9:7, and bit 3 reads back as 0. A status read leaves bits 9:7 unchanged. A general call decoded in the same cycle as the clear wins.
- R12: Register reads return data one clock after the read strobe. Control reads back bits 2:0, and identity registers read back their 7-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after reg_rd |
| irq | output | 1 | Stop-after-match interrupt |

## Verification
A change on a bus pin passes through two synchroniser flops and one edge register, so the internal state and the SDA drive follow it at the third rising clock edge. The bench holds every SCL half period for ten clocks. It drives the bus on falling clock edges and reads the acknowledge in the middle of the SCL high phase, long after the target's drive has settled. Register reads are due one cycle after the strobe. The monitor compares them on the falling edge after that cycle, against values the read task queued in order.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants of the I2C target controller.
// Assumes a 3-bit register select and a 16-bit status word.
package i2c_tgt_pkg;
    localparam int NUM_ID   = 4;
    localparam int ADDR_W   = 7;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = $clog2(NUM_ID);

    localparam logic [2:0] SEL_STAT = 3'd0;
    localparam logic [2:0] SEL_CTRL = 3'd1;
    localparam logic [2:0] SEL_ALT  = 3'd6;
    localparam logic [2:0] SEL_DATA = 3'd7;

    localparam int CB_GCEN  = 0;
    localparam int CB_FNACK = 1;
    localparam int CB_IRQEN = 2;
    localparam int CB_GCCLR = 3;

    typedef enum logic [2:0] {
        EN_IDLE, EN_ADDR, EN_ACK, EN_RX, EN_TX, EN_TACK
    } eng_state_t;
endpackage

// File: rtl/i2c_tgt_linemon.sv
// Synchronises SCL/SDA and produces one-cycle pulses for SCL edges,
// start (SDA falls, SCL high) and stop (SDA rises, SCL high).
// Assumes the system clock oversamples SCL by several times.
module i2c_tgt_linemon #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_N-1:0] scl_sy, sda_sy;
    logic scl_d, sda_d;

    // synchroniser chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC_N-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC_N-2:0], sda_i};
            scl_d  <= scl_sy[SYNC_N-1];
            sda_d  <= sda_sy[SYNC_N-1];
        end
    end

    assign scl_s    = scl_sy[SYNC_N-1];
    assign sda_s    = sda_sy[SYNC_N-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_fifo.sv
// Small first-word-fall-through FIFO; pushes when full and pops when
// empty are ignored; flush empties it in one cycle.
module i2c_tgt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r7_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> !empty);
    a_r7_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !flush) |=> !full);
endmodule

// File: rtl/i2c_tgt_engine.sv
// Bit-level target state machine: shifts the address and data bytes,
// asks the parent for ACK decisions, drives ACK and transmit bits.
// Assumes SDA output changes are only made after an SCL falling edge.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              ack_addr,
    input  logic              ack_data,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              addr_done,
    output logic              data_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_pop,
    output logic              sda_oe
);
    localparam logic [3:0] LAST = 4'(BYTE_W - 1);

    eng_state_t        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg, tx_next;
    logic              ack_sel, phase, dir_rd, mack, last_bit;

    assign rx_byte   = {shreg[BYTE_W-2:0], sda_s};
    assign last_bit  = scl_rise && (cnt == LAST) && !start_p && !stop_p;
    assign addr_done = last_bit && (state == EN_ADDR);
    assign data_done = last_bit && (state == EN_RX);
    assign tx_next   = tx_valid ? tx_data : '1;
    assign tx_pop    = scl_fall && phase &&
                       (((state == EN_ACK) && ack_sel && dir_rd) ||
                        ((state == EN_TACK) && mack));

    // SDA pull-down from the current phase
    always_comb begin
        case (state)
            EN_ACK:  sda_oe = phase & ack_sel;
            EN_TX:   sda_oe = ~shreg[BYTE_W-1];
            EN_TACK: sda_oe = ~phase & ~shreg[BYTE_W-1];
            default: sda_oe = 1'b0;
        endcase
    end

    // protocol sequencing; bus conditions override every state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= EN_IDLE; cnt <= '0; shreg <= '0;
            ack_sel <= 1'b0; phase <= 1'b0; dir_rd <= 1'b0; mack <= 1'b0;
        end else if (start_p) begin
            state <= EN_ADDR; cnt <= '0; phase <= 1'b0;
        end else if (stop_p) begin
            state <= EN_IDLE; phase <= 1'b0;
        end else begin
            case (state)
                EN_ADDR, EN_RX: if (scl_rise) begin
                    shreg <= rx_byte;
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state   <= EN_ACK;
                        phase   <= 1'b0;
                        ack_sel <= (state == EN_ADDR) ? ack_addr : ack_data;
                        dir_rd  <= (state == EN_ADDR) & rx_byte[0];
                    end
                end
                EN_ACK: if (scl_fall) begin
                    if (!phase) phase <= 1'b1;
                    else begin
                        phase <= 1'b0;
                        cnt   <= '0;
                        if (!ack_sel) state <= EN_IDLE;
                        else if (dir_rd) begin
                            state <= EN_TX;
                            shreg <= tx_next;
                        end else state <= EN_RX;
                    end
                end
                EN_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            state <= EN_TACK;
                            phase <= 1'b0;
                        end
                    end
                    if (scl_fall) shreg <= {shreg[BYTE_W-2:0], 1'b1};
                end
                EN_TACK: begin
                    if (scl_fall && !phase) phase <= 1'b1;
                    else if (scl_rise && phase) mack <= ~sda_s;
                    else if (scl_fall && phase) begin
                        phase <= 1'b0;
                        cnt   <= '0;
                        if (mack) begin
                            state <= EN_TX;
                            shreg <= tx_next;
                        end else state <= EN_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r2_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2c_tgt_status.sv
// Top of the I2C target: identity compare, general-call decode, status
// word with per-field clear rules, register port and both FIFOs.
// Assumes 7-bit addressing only and no clock stretching.
module i2c_tgt_status
    import i2c_tgt_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic addr_done, data_done, tx_pop, ack_addr, ack_data;
    logic [BYTE_W-1:0] rx_byte, tx_dout, rx_dout;
    logic tx_empty, tx_full, rx_empty, rx_full, tx_push, rx_push, rx_pop;

    logic [ADDR_W-1:0] id_q [NUM_ID];
    logic [ADDR_W-1:0] alt_q;
    logic gc_en, fnack, irq_en;
    logic st_active, st_reps, st_stop, st_gcf, st_busy, st_nack;
    logic [IDX_W-1:0] st_idx, hit_idx;
    logic [1:0] st_gcid;
    logic in_txn, gc_pend, id_hit, is_sbyte, is_gc, gc_rst, gc_clr, stat_rd;
    logic [15:0] status_w;
    logic [2:0]  id_sel;

    i2c_tgt_linemon u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2c_tgt_engine u_eng (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .ack_addr(ack_addr), .ack_data(ack_data), .tx_data(tx_dout),
        .tx_valid(~tx_empty), .addr_done(addr_done), .data_done(data_done),
        .rx_byte(rx_byte), .tx_pop(tx_pop), .sda_oe(sda_oe)
    );

    i2c_tgt_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(gc_rst), .push(tx_push), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    i2c_tgt_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(gc_rst), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    // identity compare; the lowest matching index wins
    always_comb begin
        id_hit  = 1'b0;
        hit_idx = '0;
        for (int k = NUM_ID - 1; k >= 0; k--) begin
            if (rx_byte[BYTE_W-1:1] == id_q[k]) begin
                id_hit  = 1'b1;
                hit_idx = IDX_W'(k);
            end
        end
    end

    assign is_sbyte = (rx_byte == 8'h01);
    assign is_gc    = (rx_byte == 8'h00) & gc_en;
    assign ack_addr = is_gc | (id_hit & ~is_sbyte & ~fnack & (~rx_byte[0] | ~tx_empty));
    assign ack_data = gc_pend | ~fnack;
    assign gc_rst   = data_done & gc_pend & (rx_byte == 8'h06);
    assign gc_clr   = reg_wr & (reg_sel == SEL_CTRL) & reg_wdata[CB_GCCLR];
    assign stat_rd  = reg_rd & (reg_sel == SEL_STAT);
    assign tx_push  = reg_wr & (reg_sel == SEL_DATA) & ~tx_full;
    assign rx_pop   = reg_rd & (reg_sel == SEL_DATA);
    assign rx_push  = data_done & ack_data & ~rx_full & (~gc_pend | rx_byte[0]);
    assign id_sel   = reg_sel - 3'd2;
    assign irq      = st_stop & irq_en;
    assign status_w = {1'b0, st_active, st_reps, st_idx, st_stop, st_gcid,
                       st_gcf, st_busy, st_nack, 5'b0};

    // configuration registers; a general-call reset restores defaults
    always_ff @(posedge clk) begin
        if (!rst_n || gc_rst) begin
            for (int k = 0; k < NUM_ID; k++) id_q[k] <= '0;
            alt_q <= '0; gc_en <= 1'b0; fnack <= 1'b0; irq_en <= 1'b0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_CTRL) begin
                gc_en  <= reg_wdata[CB_GCEN];
                fnack  <= reg_wdata[CB_FNACK];
                irq_en <= reg_wdata[CB_IRQEN];
            end else if (reg_sel == SEL_ALT) alt_q <= reg_wdata[ADDR_W-1:0];
            else if (reg_sel != SEL_DATA) id_q[id_sel[IDX_W-1:0]] <= reg_wdata[ADDR_W-1:0];
        end
    end

    // status word: clears first so that same-cycle sets take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_active <= 1'b0; st_reps <= 1'b0; st_idx <= '0; st_stop <= 1'b0;
            st_gcid <= '0; st_gcf <= 1'b0; st_busy <= 1'b0; st_nack <= 1'b0;
            in_txn <= 1'b0; gc_pend <= 1'b0;
        end else begin
            if (gc_clr) begin
                st_gcf  <= 1'b0;
                st_gcid <= '0;
            end
            st_stop <= (stop_p & st_active) | (st_stop & ~stat_rd);
            if (start_p) begin
                st_busy <= 1'b1;
                in_txn  <= 1'b1;
                gc_pend <= 1'b0;
                if (in_txn) st_reps <= 1'b1;
            end
            if (stop_p) begin
                st_active <= 1'b0; st_reps <= 1'b0; st_busy <= 1'b0;
                in_txn <= 1'b0; gc_pend <= 1'b0;
            end
            if (addr_done) begin
                if (id_hit | is_sbyte | is_gc) st_active <= 1'b1;
                else st_busy <= 1'b0;
                if (id_hit & ~is_sbyte) st_idx <= hit_idx;
                st_nack <= id_hit & ~is_sbyte & ~ack_addr;
                gc_pend <= is_gc;
            end
            if (data_done) begin
                st_nack <= ~ack_data;
                if (gc_pend) begin
                    gc_pend <= 1'b0;
                    st_gcf  <= 1'b1;
                    if (rx_byte == 8'h06) st_gcid <= 2'b01;
                    else if (rx_byte == 8'h04) st_gcid <= 2'b10;
                    else if (rx_byte[0] && rx_byte[BYTE_W-1:1] == alt_q) st_gcid <= 2'b11;
                end
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) begin
            case (reg_sel)
                SEL_STAT: reg_rdata <= status_w;
                SEL_CTRL: reg_rdata <= {13'b0, irq_en, fnack, gc_en};
                SEL_ALT:  reg_rdata <= {9'b0, alt_q};
                SEL_DATA: reg_rdata <= rx_empty ? 16'h0 : {8'b0, rx_dout};
                default:  reg_rdata <= {9'b0, id_q[id_sel[IDX_W-1:0]]};
            endcase
        end
    end

    a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !(status_w[14] || status_w[13] || status_w[6]));
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stop_p) |=> !status_w[10]);
    a_r5_rstart_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && in_txn) |=> status_w[13]);
    a_r11_gc_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && gc_pend) |=> status_w[7]);
endmodule

// File: tb/i2c_tgt_status_test.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them when read data is due; bus tasks model an I2C master.
module i2c_tgt_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] reg_sel = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0, rd_seen = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic sda_oe, irq, sda_bus;
    int checks = 0, fails = 0;
    logic [15:0] q_exp[$];
    string q_tag[$];

    assign sda_bus = sda_m & ~sda_oe;
    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_tgt_status uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= reg_rd;

    // monitor: pop the expected word when read data is due
    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_exp.size() == 0) chk(reg_rdata, 16'hxxxx, "scoreboard underflow");
            else chk(reg_rdata, q_exp.pop_front(), q_tag.pop_front());
        end
    end

    task automatic half();
        repeat (H) @(negedge clk);
    endtask
    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic rd(input logic [2:0] s, input logic [15:0] e, input string t);
        q_exp.push_back(e); q_tag.push_back(t);
        @(negedge clk); reg_sel = s; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask
    task automatic bstart();
        sda_m = 1'b0; half(); scl_m = 1'b0; half();
    endtask
    task automatic brstart();
        sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask
    task automatic bstop();
        sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
    endtask
    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
        end
        sda_m = 1'b1; half(); scl_m = 1'b1;
        repeat (H / 2) @(negedge clk);
        ack = ~sda_bus;
        repeat (H / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask
    task automatic rbyte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half(); scl_m = 1'b1;
            repeat (H / 2) @(negedge clk);
            b[i] = sda_bus;
            repeat (H / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = ~mack; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic finish_run();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000 * H) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 16'h0000, "R1 status after reset");
        chk({15'b0, sda_oe}, 16'h0, "R1 sda idle");
        chk({15'b0, irq}, 16'h0, "R1 irq idle");
        wr(3'd2, 8'h10); wr(3'd3, 8'h21); wr(3'd4, 8'h32); wr(3'd5, 8'h43);
        wr(3'd1, 8'h04);
        rd(3'd5, 16'h0043, "R12 identity readback");
        // R2 / R7 write to identity 3
        bstart();
        wbyte({7'h43, 1'b0}, a); chk({15'b0, a}, 16'h1, "R2 address ack");
        wbyte(8'hA5, a); chk({15'b0, a}, 16'h1, "R7 data ack");
        wbyte(8'h5A, a);
        rd(3'd0, 16'h5840, "R2 matched status");
        bstop();
        chk({15'b0, irq}, 16'h1, "R4 irq on stop");
        rd(3'd0, 16'h1C00, "R4 stop flag");
        rd(3'd0, 16'h1800, "R4 read clears stop");
        chk({15'b0, irq}, 16'h0, "R4 irq cleared");
        rd(3'd7, 16'h00A5, "R7 first byte");
        rd(3'd7, 16'h005A, "R7 second byte");
        rd(3'd7, 16'h0000, "R7 empty");
        // R3 unmatched
        bstart();
        wbyte({7'h55, 1'b0}, a); chk({15'b0, a}, 16'h0, "R3 no ack");
        rd(3'd0, 16'h1800, "R3 busy cleared");
        bstop();
        rd(3'd0, 16'h1800, "R3 no stop flag");
        // R5 repeated start and R6 read with data
        wr(3'd7, 8'hC3); wr(3'd7, 8'h3C);
        bstart();
        wbyte({7'h21, 1'b0}, a);
        brstart();
        wbyte({7'h21, 1'b1}, a); chk({15'b0, a}, 16'h1, "R6 read address ack");
        rbyte(1'b1, b); chk({8'b0, b}, 16'h00C3, "R6 first tx byte");
        rbyte(1'b0, b); chk({8'b0, b}, 16'h003C, "R6 second tx byte");
        rd(3'd0, 16'h6840, "R5 repeated start flag");
        bstop();
        rd(3'd0, 16'h0C00, "R5 stop clears repeat");
        // R6 empty transmit FIFO and forced NACK
        bstart();
        wbyte({7'h10, 1'b1}, a); chk({15'b0, a}, 16'h0, "R6 empty nack");
        rd(3'd0, 16'h4060, "R6 nack flag");
        bstop();
        rd(3'd0, 16'h0420, "R6 after stop");
        wr(3'd1, 8'h06);
        bstart();
        wbyte({7'h32, 1'b0}, a); chk({15'b0, a}, 16'h0, "R6 forced nack");
        rd(3'd0, 16'h5060, "R6 forced nack flag");
        bstop();
        rd(3'd0, 16'h1420, "R6 forced after stop");
        wr(3'd1, 8'h04);
        // R8 start byte
        bstart();
        wbyte(8'h01, a); chk({15'b0, a}, 16'h0, "R8 start byte no ack");
        rd(3'd0, 16'h5040, "R8 active");
        bstop();
        rd(3'd0, 16'h1400, "R8 stop flag");
        // R9 general call disabled then enabled
        bstart();
        wbyte(8'h00, a); chk({15'b0, a}, 16'h0, "R9 disabled no ack");
        rd(3'd0, 16'h1000, "R9 disabled status");
        bstop();
        rd(3'd0, 16'h1000, "R9 disabled after stop");
        wr(3'd1, 8'h05);
        bstart();
        wbyte(8'h00, a); chk({15'b0, a}, 16'h1, "R9 enabled ack");
        wbyte(8'h04, a);
        bstop();
        rd(3'd0, 16'h1680, "R9 program address code");
        rd(3'd7, 16'h0000, "R9 command not queued");
        wr(3'd6, 8'h2A);
        bstart();
        wbyte(8'h00, a); wbyte(8'h55, a);
        bstop();
        rd(3'd0, 16'h1780, "R9 hardware call alt match");
        rd(3'd7, 16'h0055, "R9 hardware byte queued");
        rd(3'd0, 16'h1380, "R11 status read keeps gc bits");
        // R11 clear bit
        wr(3'd1, 8'h0D);
        rd(3'd0, 16'h1000, "R11 clear gc bits");
        rd(3'd1, 16'h0005, "R11 clear bit not stored");
        // R10 general-call reset
        wr(3'd7, 8'h99);
        bstart();
        wbyte(8'h00, a); wbyte(8'h06, a);
        bstop();
        rd(3'd0, 16'h1580, "R10 reset code kept");
        rd(3'd1, 16'h0000, "R10 control default");
        rd(3'd5, 16'h0000, "R10 identity default");
        rd(3'd6, 16'h0000, "R10 alt default");
        wr(3'd2, 8'h10); wr(3'd1, 8'h04);
        bstart();
        wbyte({7'h10, 1'b1}, a); chk({15'b0, a}, 16'h0, "R10 tx FIFO flushed");
        bstop();
        rd(3'd0, 16'h05A0, "R10 gc field survives");
        finish_run();
    end
endmodule